// File: doc/BRIEF.md
# Output Port Register with Timed Low Pulse

This block holds an 8-bit control port whose bits drive system-level lines: bit 0 is the processor reset line and bit 1 is the A20 address gate. Bits 4 and 5 carry the output-buffer-full and input-buffer-empty indications. Bits 6 and 7 carry the keyboard clock and keyboard data outputs. Host-side address decoding is not part of the block. It sees three strobes instead: one loads the port from a byte, one captures the port value for reading, and one presents a controller command code.

A command in the range F0h to FFh asks for a timed pulse. Its low four bits form a select mask in which a 0 means "pulse this bit" and a 1 means "leave this bit alone". Each selected bit is driven low for `PULSE_CYCLES` clock cycles and then returns to its stored value. The default is 1200 cycles, which is 6 µs at 200 MHz. Pulsing bit 0 asserts the processor reset line for that time. A `busy` output is high for the whole pulse. Loads and new pulse commands that arrive while busy are dropped.

The reset input is asserted asynchronously and released synchronously through a two-stage synchronizer.

Top module: `outport_pulser`

## Requirements
- R1: While reset is active, and until the first accepted request after it, `port_out` is FFh, `busy` is 0 and `rd_data` is 00h.
- R2: With `busy` low, a `wr_stb` cycle loads `wr_data` into the port, and `port_out` shows it from the next cycle. Bit 0 is the reset line, bit 1 is the A20 gate, and bits 4 to 7 pass the stored value through.
- R3: A `rd_stb` cycle captures the value on `port_out` in that cycle into `rd_data`, which is visible from the next cycle. `rd_data` holds its value when `rd_stb` is low.
- R4: With `busy` low, a `cmd_stb` cycle with `cmd_code[7:4]` = Fh drives low every bit i in 0..3 where `cmd_code[i]` = 0. The low level starts in the next cycle and lasts exactly `PULSE_CYCLES` cycles.
- R5: During a pulse, bits 4 to 7 and the unselected bits among 0 to 3 keep their stored values.
- R6: When the pulse ends, the pulsed bits return to the value stored before the pulse.
- R7: `busy` rises in the cycle the pulse starts, stays high for exactly `PULSE_CYCLES` cycles, and falls as the pulsed bits are restored.
- R8: While `busy` is high, `wr_stb` and pulse commands have no effect on `port_out` or on the length of the pulse.
- R9: Command FFh selects no bit. It starts no pulse, leaves `busy` low and leaves `port_out` unchanged.
- R10: Commands with `cmd_code[7:4]` other than Fh are ignored.
- R11: A write and a pulse command in the same idle cycle both take effect. The pulse is applied over the newly written value, and that value is restored afterwards.
- R12: A read during a pulse returns the driven value, with the pulsed bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Load request for the port |
| wr_data | input | 8 | Byte to load |
| rd_stb | input | 1 | Read capture request |
| rd_data | output | 8 | Last captured port value |
| cmd_stb | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| port_out | output | 8 | Driven port lines |
| busy | output | 1 | High while a pulse is in progress |

## Verification
The assertions assume that each strobe is a single-cycle request sampled at the rising edge. They also assume the strobes are held low while reset is active and during the synchronizer release cycles, so the first sampled history after reset is idle. The stimulus drives every input just after the falling edge and keeps all strobes low for several cycles around each reset. The random phase mixes pulse codes, the all-ones code, unrelated codes, and loads that collide with a running pulse, so the rules for dropped requests are exercised as well as the accepted ones.

// File: rtl/outport_pkg.sv
package outport_pkg;

  // Value taken by the port on reset: reset line released, A20 enabled.
  localparam logic [7:0] PORT_RESET_VAL = 8'hFF;

  // Two-state pulse timer.
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;

endpackage

// File: rtl/outport_rst_sync.sv
module outport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/outport_cmd_dec.sv
module outport_cmd_dec #(
  parameter int CMD_W      = 8,
  parameter int PULSE_BITS = 4
) (
  input  logic                  cmd_stb,
  input  logic [CMD_W-1:0]      cmd_code,
  input  logic                  busy,
  output logic                  start,
  output logic [PULSE_BITS-1:0] sel_mask
);

  localparam int HI_W = CMD_W - PULSE_BITS;

  logic [HI_W-1:0] hi_field;
  logic            is_pulse_cmd;

  always_comb begin
    hi_field     = cmd_code[CMD_W-1:PULSE_BITS];
    is_pulse_cmd = &hi_field;
    // A zero in the low field selects a bit for pulsing.
    sel_mask     = ~cmd_code[PULSE_BITS-1:0];
    start        = cmd_stb && !busy && is_pulse_cmd && (|sel_mask);
  end

endmodule

// File: rtl/outport_pulse_timer.sv
module outport_pulse_timer
  import outport_pkg::*;
#(
  parameter int PULSE_BITS   = 4,
  parameter int PULSE_CYCLES = 1200
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  start,
  input  logic [PULSE_BITS-1:0] sel_mask,
  output logic                  busy,
  output logic [PULSE_BITS-1:0] act_mask
);

  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_CYCLES - 1);

  tmr_state_e            state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [PULSE_BITS-1:0] mask_q, mask_d;
  logic                  cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    mask_d  = mask_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      TMR_IDLE: begin
        if (start) begin
          state_d = TMR_RUN;
          cnt_d   = CNT_LOAD;
          mask_d  = sel_mask;
          cnt_en  = 1'b1;
        end
      end
      TMR_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          state_d = TMR_IDLE;
          mask_d  = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = TMR_IDLE;
        mask_d  = '0;
        cnt_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= TMR_IDLE;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      mask_q  <= mask_d;
    end
  end

  assign busy     = (state_q == TMR_RUN);
  assign act_mask = mask_q;

endmodule

// File: rtl/outport_reg.sv
module outport_reg
  import outport_pkg::*;
#(
  parameter int PORT_W     = 8,
  parameter int PULSE_BITS = 4
) (
  input  logic                  clk,
  input  logic                  srst_n,
  input  logic                  wr_stb,
  input  logic [PORT_W-1:0]     wr_data,
  input  logic                  rd_stb,
  input  logic                  busy,
  input  logic [PULSE_BITS-1:0] act_mask,
  output logic [PORT_W-1:0]     port_out,
  output logic [PORT_W-1:0]     rd_data
);

  logic [PORT_W-1:0] port_q, port_d;
  logic [PORT_W-1:0] rd_q, rd_d;
  logic [PORT_W-1:0] drive;
  logic              port_en;
  logic              rd_en;

  // Writes are dropped while a pulse is running.
  always_comb begin
    port_en = wr_stb && !busy;
    port_d  = wr_data;
    rd_en   = rd_stb;
    rd_d    = drive;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      port_q <= PORT_RESET_VAL[PORT_W-1:0];
    end else if (port_en) begin
      port_q <= port_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  // Only the low PULSE_BITS lines can be forced low.
  for (genvar i = 0; i < PORT_W; i++) begin : g_drive
    if (i < PULSE_BITS) begin : g_pulsed
      assign drive[i] = port_q[i] & ~(busy & act_mask[i]);
    end else begin : g_plain
      assign drive[i] = port_q[i];
    end
  end

  assign port_out = drive;
  assign rd_data  = rd_q;

endmodule

// File: rtl/outport_pulser.sv
module outport_pulser #(
  parameter int PORT_W       = 8,
  parameter int PULSE_BITS   = 4,
  parameter int PULSE_CYCLES = 1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [PORT_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [PORT_W-1:0] rd_data,
  input  logic              cmd_stb,
  input  logic [PORT_W-1:0] cmd_code,
  output logic [PORT_W-1:0] port_out,
  output logic              busy
);

  logic                  srst_n;
  logic                  start;
  logic [PULSE_BITS-1:0] sel_mask;
  logic [PULSE_BITS-1:0] act_mask;
  logic                  busy_w;

  outport_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  outport_cmd_dec #(
    .CMD_W      (PORT_W),
    .PULSE_BITS (PULSE_BITS)
  ) u_cmd_dec (
    .cmd_stb  (cmd_stb),
    .cmd_code (cmd_code),
    .busy     (busy_w),
    .start    (start),
    .sel_mask (sel_mask)
  );

  outport_pulse_timer #(
    .PULSE_BITS   (PULSE_BITS),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_timer (
    .clk      (clk),
    .srst_n   (srst_n),
    .start    (start),
    .sel_mask (sel_mask),
    .busy     (busy_w),
    .act_mask (act_mask)
  );

  outport_reg #(
    .PORT_W     (PORT_W),
    .PULSE_BITS (PULSE_BITS)
  ) u_reg (
    .clk      (clk),
    .srst_n   (srst_n),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb),
    .busy     (busy_w),
    .act_mask (act_mask),
    .port_out (port_out),
    .rd_data  (rd_data)
  );

  assign busy = busy_w;

endmodule

// File: rtl/outport_pulser_chk.sv
module outport_pulser_chk #(
  parameter int PORT_W       = 8,
  parameter int PULSE_CYCLES = 1200
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              rd_stb,
  input logic              cmd_stb,
  input logic [PORT_W-1:0] cmd_code,
  input logic [PORT_W-1:0] port_out,
  input logic [PORT_W-1:0] rd_data,
  input logic              busy
);

  // Length of the current run of busy cycles.
  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (busy) begin
      run_len <= run_len + 1;
    end else begin
      run_len <= '0;
    end
  end

  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_stb) && ($past(cmd_code[7:4]) == 4'hF))); // R7

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == PULSE_CYCLES)); // R7

  AST_SELECTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ((port_out[3:0] & ~$past(cmd_code[3:0])) == 4'h0)); // R4

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(port_out)); // R8

  AST_UPPER_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $stable(port_out[7:4])); // R5

  AST_OTHER_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cmd_stb) && ($past(cmd_code[7:4]) != 4'hF) && !$past(wr_stb) && !$past(busy))
      |-> ($stable(port_out) && !busy)); // R10

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb) |-> $stable(rd_data)); // R3

endmodule

bind outport_pulser outport_pulser_chk #(
  .PORT_W       (PORT_W),
  .PULSE_CYCLES (PULSE_CYCLES)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_stb   (wr_stb),
  .rd_stb   (rd_stb),
  .cmd_stb  (cmd_stb),
  .cmd_code (cmd_code),
  .port_out (port_out),
  .rd_data  (rd_data),
  .busy     (busy)
);

// File: tb/outport_pulser_tb_top.sv
module outport_pulser_tb_top;

  localparam int P = 20;

  logic       clk;
  logic       rst_n;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       rd_stb;
  logic [7:0] rd_data;
  logic       cmd_stb;
  logic [7:0] cmd_code;
  logic [7:0] port_out;
  logic       busy;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 0;
  bit  model_cmp = 0;

  // Reference state, advanced once per rising edge.
  logic [7:0] m_reg, m_rd;
  logic [3:0] m_mask;
  logic       m_busy;
  int         m_cnt;

  outport_pulser #(.PULSE_CYCLES(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .cmd_stb(cmd_stb),
    .cmd_code(cmd_code), .port_out(port_out), .busy(busy)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] drive_of(logic [7:0] r, logic b, logic [3:0] m);
    return b ? (r & ~{4'h0, m}) : r;
  endfunction

  function automatic logic [7:0] pulsed(logic [7:0] r, logic [7:0] code);
    return r & ~{4'h0, ~code[3:0]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = 8'hFF; m_rd = 8'h00; m_mask = 4'h0; m_busy = 1'b0; m_cnt = 0;
    end else begin
      logic [7:0] drv;
      drv = drive_of(m_reg, m_busy, m_mask);
      if (rd_stb) m_rd = drv;
      if (!m_busy) begin
        if (wr_stb) m_reg = wr_data;
        if (cmd_stb && cmd_code[7:4] == 4'hF && cmd_code[3:0] != 4'hF) begin
          m_busy = 1'b1; m_mask = ~cmd_code[3:0]; m_cnt = P - 1;
        end
      end else if (m_cnt == 0) begin
        m_busy = 1'b0; m_mask = 4'h0;
      end else begin
        m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_cmp && rst_n) begin
      check(m_busy ? "R4" : "R2", port_out, drive_of(m_reg, m_busy, m_mask));
      check("R7", {7'h0, busy}, {7'h0, m_busy});
      check("R3", rd_data, m_rd);
    end
  end

  task automatic idle();
    wr_stb = 0; rd_stb = 0; cmd_stb = 0;
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(logic [7:0] d);
    wr_stb = 1; wr_data = d; step(); idle();
  endtask

  task automatic do_cmd(logic [7:0] c);
    cmd_stb = 1; cmd_code = c; step(); idle();
  endtask

  task automatic do_read();
    rd_stb = 1; step(); idle();
  endtask

  initial begin
    #(5.0 * 60000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    idle(); wr_data = 0; cmd_code = 0;
    rst_n = 0;
    step(3);
    check("R1", port_out, 8'hFF);
    check("R1", {7'h0, busy}, 8'h00);
    check("R1", rd_data, 8'h00);
    rst_n = 1;
    step(4);
    check("R1", port_out, 8'hFF);
    model_cmp = 1;

    // R2: load and observe
    do_write(8'hA5);
    check("R2", port_out, 8'hA5);
    do_write(8'h3C);
    check("R2", port_out, 8'h3C);
    // R3: capture and hold
    do_read();
    check("R3", rd_data, 8'h3C);
    do_write(8'hC3);
    step(2);
    check("R3", rd_data, 8'h3C);

    // R4/R5/R7: pulse bit 0 (reset line), value C3
    do_cmd(8'hFE);
    for (int i = 0; i < P; i++) begin
      check("R4", port_out, 8'hC2);
      check("R7", {7'h0, busy}, 8'h01);
      if (i == 3) begin
        // R8: write and second pulse dropped; R12 read during pulse
        wr_stb = 1; wr_data = 8'h00; cmd_stb = 1; cmd_code = 8'hF0; rd_stb = 1;
      end else idle();
      step();
      i = i;
    end
    idle();
    check("R6", port_out, 8'hC3);
    check("R7", {7'h0, busy}, 8'h00);
    check("R12", rd_data, 8'hC2);

    // R5: pulse bits 1 and 3 on FFh, upper and others kept
    do_write(8'hFF);
    do_cmd(8'hF5);
    check("R5", port_out, pulsed(8'hFF, 8'hF5));
    step(P);
    check("R6", port_out, 8'hFF);

    // R9: all-ones command
    do_cmd(8'hFF);
    check("R9", port_out, 8'hFF);
    check("R9", {7'h0, busy}, 8'h00);
    // R10: unrelated codes
    do_cmd(8'hE0);
    check("R10", port_out, 8'hFF);
    check("R10", {7'h0, busy}, 8'h00);
    do_cmd(8'h7E);
    check("R10", {7'h0, busy}, 8'h00);

    // R11: write and pulse together
    wr_stb = 1; wr_data = 8'h5B; cmd_stb = 1; cmd_code = 8'hF0;
    step(); idle();
    check("R11", port_out, 8'h50);
    step(P);
    check("R11", port_out, 8'h5B);

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      wr_stb  = ($urandom % 4) == 0;
      wr_data = 8'($urandom);
      rd_stb  = ($urandom % 3) == 0;
      cmd_stb = ($urandom % 10) == 0;
      cmd_code = ($urandom % 2) ? {4'hF, 4'($urandom)} : 8'($urandom);
      step();
    end
    idle();
    step(P + 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule